// File: doc/BRIEF.md
# Line Defect Alarm and Interrupt Registers

This block gathers the defect flags of a line interface's receive and transmit paths. It presents them to a host through three byte-wide registers on a small strobe-driven register bus. One register mirrors the present level of six defect flags. A second register latches, for four of those flags, the fact that the flag changed state. A rise (defect declared) and a fall (defect cleared) both count as a change. The third register chooses which latched bits may pull the active-low interrupt line. The defect flags reach the block as levels that are already synchronous to its clock.

A host waits for `irq_n` to go low. It then reads the latched-change register, which returns the pending changes and clears them in the same access. It reads the live register to learn the present condition. The register bus uses a three-state access controller. BUS_IDLE waits for `bus_cs`. BUS_IDLE→BUS_ACCESS is taken when `bus_cs` is sampled high. BUS_ACCESS lasts one cycle, in which the read or write takes effect. BUS_ACCESS→BUS_HOLD is taken unconditionally. BUS_HOLD stays while `bus_cs` remains high. BUS_HOLD→BUS_IDLE is taken when `bus_cs` is sampled low. Address, direction and write data must be held steady while `bus_cs` is high. Read data appears on `bus_rdata` after the BUS_ACCESS cycle's clock edge and is held until the next read.

Top module: `line_alarm_irq`

## Requirements
- R1: The live register at offset 0x3 returns the present defect levels, one bit per flag: bit 0 transmit drive-monitor fault, bit 1 receive loss of signal, bit 2 receive loss of lock, bit 3 FIFO-limit alarm, bit 4 analog loss of signal, bit 5 digital loss of signal. Bits 7 and 6 read 0.
- R2: A change in either direction of input bit k, for k from 0 to 3, sets bit k of the latched-change register at offset 0x2 on the clock edge that first sees the new level. Bits 7 to 4 of that register read 0. Inputs 4 and 5 never set any latched bit.
- R3: A read of offset 0x2 returns the latched bits as they stood before that access, and clears them. Latched bits are never cleared at any other time.
- R4: If a change arrives on the same edge as the clearing read, its bit is set afterwards. The read returns the bit's value from before that edge.
- R5: The enable register at offset 0x1 is written with the low four data bits. It reads back with bits 7 to 4 at 0, and it changes only on a write to offset 0x1.
- R6: `irq_n` is low exactly while some latched bit is set and its enable bit is 1. A latched bit whose enable is 0 still latches and still reads back.
- R7: `irq_n` returns high on the edge that clears the last enabled pending bit, whether that edge is a clearing read or an enable write. It rises at no other time.
- R8: During and after reset, all latched bits and enables are 0 and `irq_n` is high. Defect levels already present at reset produce no change event.
- R9: One strobe makes exactly one access. Holding `bus_cs` high does not repeat a clear, and changes that arrive during the hold are kept. Writes to offsets 0x2 and 0x3 have no effect.
- R10: Reads of unmapped offsets (anything other than 0x1, 0x2, 0x3) return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| defect_in | input | 6 | Synchronous defect levels, bit order as in R1 |
| bus_cs | input | 1 | Access strobe, one access per high period |
| bus_we | input | 1 | 1 = write, 0 = read, held while strobe is high |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit data, a 4-bit offset, six live flags and four latching flags. Four address bits make unmapped offsets such as 0x0 and 0x7 reachable. Six live flags against four latching ones let the bench confirm that the two loss-of-signal flags show up live but never latch. With four latching bits and enables, the bench can run a single-bit enable mask alongside several pending changes. This covers the disabled-but-latched case and the case of a change landing exactly on the clearing edge.

// File: rtl/line_alarm_pkg.sv
package line_alarm_pkg;

    // Register-bus access controller states
    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_ACCESS = 2'd1,
        BUS_HOLD   = 2'd2
    } bus_state_e;

endpackage

// File: rtl/line_alarm_bus_ctrl.sv
module line_alarm_bus_ctrl
    import line_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    output logic       acc,
    output bus_state_e state
);

    bus_state_e state_q;
    bus_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   if (cs) state_d = BUS_ACCESS;
            BUS_ACCESS: state_d = BUS_HOLD;
            BUS_HOLD:   if (!cs) state_d = BUS_IDLE;
            default:    state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        acc   = 1'b0;
        state = state_q;
        unique case (state_q)
            BUS_IDLE:   acc = 1'b0;
            BUS_ACCESS: acc = 1'b1;
            BUS_HOLD:   acc = 1'b0;
            default:    acc = 1'b0;
        endcase
    end

endmodule

// File: rtl/line_alarm_edge_det.sv
module line_alarm_edge_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] chg
);

    logic [W-1:0] prev_q;

    // The previous-level register follows the input during reset as well,
    // so the first compare after reset sees no difference.
    always_ff @(posedge clk) begin
        prev_q <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign chg[i] = rst_n & (lvl[i] ^ prev_q[i]);
    end

endmodule

// File: rtl/line_alarm_latch.sv
module line_alarm_latch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr,
    input  logic         en_wr,
    input  logic [N-1:0] en_wdata,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] en_q,
    output logic         irq_n
);

    // A change event wins over a clear arriving on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~{N{clr}}) | evt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end
    end

    assign irq_n = ~|(pend_q & en_q);

endmodule

// File: rtl/line_alarm_irq.sv
module line_alarm_irq
    import line_alarm_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int N_LIVE   = 6,
    parameter int N_IRQ    = 4,
    parameter int OFS_EN   = 1,
    parameter int OFS_STAT = 2,
    parameter int OFS_LIVE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LIVE-1:0] defect_in,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n
);

    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(OFS_LIVE);
    localparam int LIVE_PAD = DATA_W - N_LIVE;
    localparam int IRQ_PAD  = DATA_W - N_IRQ;

    bus_state_e        bus_state;
    logic              acc;
    logic              rd_acc;
    logic              wr_acc;
    logic              clr_stat;
    logic              wr_en;
    logic [N_IRQ-1:0]  chg;
    logic [N_IRQ-1:0]  pend_q;
    logic [N_IRQ-1:0]  en_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_wdata_hi;

    line_alarm_bus_ctrl u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (bus_cs),
        .acc   (acc),
        .state (bus_state)
    );

    line_alarm_edge_det #(.W(N_IRQ)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (defect_in[N_IRQ-1:0]),
        .chg   (chg)
    );

    assign rd_acc   = acc & ~bus_we;
    assign wr_acc   = acc &  bus_we;
    assign clr_stat = rd_acc & (bus_addr == A_STAT);
    assign wr_en    = wr_acc & (bus_addr == A_EN);

    line_alarm_latch #(.N(N_IRQ)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (chg),
        .clr      (clr_stat),
        .en_wr    (wr_en),
        .en_wdata (bus_wdata[N_IRQ-1:0]),
        .pend_q   (pend_q),
        .en_q     (en_q),
        .irq_n    (irq_n)
    );

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:N_IRQ];

    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_LIVE) begin
            rd_mux = {{LIVE_PAD{1'b0}}, defect_in};
        end else if (bus_addr == A_STAT) begin
            rd_mux = {{IRQ_PAD{1'b0}}, pend_q};
        end else if (bus_addr == A_EN) begin
            rd_mux = {{IRQ_PAD{1'b0}}, en_q};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_acc) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/line_alarm_irq_chk.sv
module line_alarm_irq_chk #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int N_LIVE   = 6,
    parameter int N_IRQ    = 4,
    parameter int OFS_EN   = 1,
    parameter int OFS_STAT = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_IRQ-1:0]         src,
    input logic                     acc,
    input logic                     we,
    input logic [ADDR_W-1:0]        addr,
    input logic [N_IRQ-1:0]         pend,
    input logic [N_IRQ-1:0]         en,
    input logic                     irq_n,
    input logic [DATA_W-1:N_LIVE]   rdata_hi
);

    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic [N_IRQ-1:0] src_prev;
    logic [N_IRQ-1:0] seen_chg;
    logic             is_clr;
    logic             is_en_wr;

    always_ff @(posedge clk) src_prev <= src;
    assign seen_chg = rst_n ? (src ^ src_prev) : '0;
    assign is_clr   = acc & ~we & (addr == A_STAT);
    assign is_en_wr = acc & we & (addr == A_EN);

    // R2
    change_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|seen_chg) |=> ((pend & $past(seen_chg)) == $past(seen_chg)));

    // R4
    clear_keeps_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_clr && (|seen_chg)) |=> ((pend & $past(seen_chg)) == $past(seen_chg)));

    // R3
    no_stray_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_clr |=> ((pend & $past(pend)) == $past(pend)));

    // R5
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_en_wr |=> $stable(en));

    // R7
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(acc));

    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (irq_n && pend == '0 && en == '0));

    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_hi == '0);

endmodule

bind line_alarm_irq line_alarm_irq_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .N_LIVE   (N_LIVE),
    .N_IRQ    (N_IRQ),
    .OFS_EN   (OFS_EN),
    .OFS_STAT (OFS_STAT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (defect_in[N_IRQ-1:0]),
    .acc      (acc),
    .we       (bus_we),
    .addr     (bus_addr),
    .pend     (pend_q),
    .en       (en_q),
    .irq_n    (irq_n),
    .rdata_hi (bus_rdata[DATA_W-1:N_LIVE])
);

// File: tb/line_alarm_irq_tb.sv
module line_alarm_irq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] defect_in = 6'b000101;
    logic       bus_cs = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n;

    always #4 clk = ~clk;

    line_alarm_irq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .defect_in (defect_in),
        .bus_cs    (bus_cs),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] obs_val;
    event       obs_ev;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    // monitor: pops one expectation per observation
    initial begin
        forever begin
            @(obs_ev);
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected observation: actual %h expected none", obs_val);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (obs_val !== e.val) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", e.tag, obs_val, e.val);
                end
            end
        end
    end

    task automatic post(input logic [7:0] v);
        obs_val = v;
        -> obs_ev;
        #1;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        exp_t x;
        x.val = {7'd0, e};
        x.tag = tag;
        exp_q.push_back(x);
        post({7'd0, irq_n});
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_t x;
        x.val = e;
        x.tag = tag;
        exp_q.push_back(x);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        @(negedge clk);
        bus_cs = 1'b0;
        post(bus_rdata);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    // read of 0x2 with a defect change landing on the clearing edge
    task automatic read_with_change(input logic [5:0] nd, input logic [7:0] e, input string tag);
        exp_t x;
        x.val = e;
        x.tag = tag;
        exp_q.push_back(x);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = 4'h2;
        @(negedge clk);
        defect_in = nd;
        @(negedge clk);
        bus_cs = 1'b0;
        post(bus_rdata);
        @(negedge clk);
    endtask

    // read of 0x2 with the strobe held, a change arriving during the hold
    task automatic read_held(input logic [5:0] nd, input logic [7:0] e, input string tag);
        exp_t x;
        x.val = e;
        x.tag = tag;
        exp_q.push_back(x);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = 4'h2;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        defect_in = nd;
        repeat (3) @(negedge clk);
        bus_cs = 1'b0;
        post(bus_rdata);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        expect_irq(1'b1, "R8 irq_n high in reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R8: levels present at reset make no event
        expect_irq(1'b1, "R8 irq_n high after reset");
        bus_read(4'h2, 8'h00, "R8 latched bits zero after reset");
        bus_read(4'h1, 8'h00, "R8 enables zero after reset");
        bus_read(4'h3, 8'h05, "R1 live levels after reset");

        // R5 enable write, upper bits read 0
        bus_write(4'h1, 8'hFF);
        bus_read(4'h1, 8'h0F, "R5 enable readback");

        // R2 cleared-direction change on loss of lock
        @(negedge clk); defect_in = 6'b000001;
        @(negedge clk);
        expect_irq(1'b0, "R6 irq_n low on enabled change");
        bus_read(4'h2, 8'h04, "R2 fall of bit 2 latched");
        expect_irq(1'b1, "R7 irq_n high after clearing read");
        bus_read(4'h2, 8'h00, "R3 cleared by read");

        // R2 declared-direction changes on two bits
        @(negedge clk); defect_in = 6'b001011;
        @(negedge clk);
        bus_read(4'h3, 8'h0B, "R1 live after rises");
        bus_read(4'h2, 8'h0A, "R2 rises of bits 1 and 3");

        // R1/R2 analog and digital flags live only
        @(negedge clk); defect_in = 6'b111011;
        @(negedge clk);
        bus_read(4'h3, 8'h3B, "R1 bits 4 and 5 live");
        bus_read(4'h2, 8'h00, "R2 bits 4 and 5 never latch");
        expect_irq(1'b1, "R6 no request from live-only flags");

        // R6 disabled bit latches but does not request
        bus_write(4'h1, 8'h01);
        @(negedge clk); defect_in = 6'b111111;
        @(negedge clk);
        expect_irq(1'b1, "R6 disabled bit keeps irq_n high");
        bus_read(4'h2, 8'h04, "R6 disabled bit still latched");

        // R4 change on the clearing edge
        bus_write(4'h1, 8'h0F);
        read_with_change(6'b111110, 8'h00, "R4 read returns pre-edge value");
        expect_irq(1'b0, "R4 same-edge change pending");
        bus_read(4'h2, 8'h01, "R4 same-edge change kept");
        expect_irq(1'b1, "R7 irq_n high after last clear");

        // R9 writes to status and live are ignored
        @(negedge clk); defect_in = 6'b111111;
        @(negedge clk);
        bus_write(4'h2, 8'hFF);
        bus_write(4'h3, 8'hFF);
        bus_read(4'h1, 8'h0F, "R9 enable untouched by other writes");
        bus_read(4'h3, 8'h3F, "R9 live untouched by write");
        bus_read(4'h2, 8'h01, "R9 status not cleared by write");

        // R9 held strobe: one clear only
        read_held(6'b111101, 8'h00, "R9 held read snapshot");
        expect_irq(1'b0, "R9 change during hold pending");
        bus_read(4'h2, 8'h02, "R9 change during hold kept");

        // R10 unmapped offsets
        bus_read(4'h0, 8'h00, "R10 offset 0 reads zero");
        bus_read(4'h7, 8'h00, "R10 offset 7 reads zero");
        expect_irq(1'b1, "R7 idle at end");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule